// File: doc/BRIEF.md
# Translation Cache with Global-Aware Flush Control

This block is a small fully associative cache of address translations. Each entry maps a virtual page number to a physical frame number and carries a valid flag and a global flag. A lookup is combinational: it returns hit and frame in the cycle it is asked. A fill installs a mapping without any software step. If the page is already present, the fill overwrites that entry. Otherwise it replaces entries in round-robin order.

A flush controller watches control events and picks one of two kinds of flush. A request to change the page-table base clears only the non-global entries. A forced flush clears every entry, global or not. The forced flush is triggered by an edge on the active-low external flush pin, a write to a memory-type range register, or a control-register write that toggles a translation-relevant bit. The controller finds such a write by comparing the old and new register values that come with the write strobe.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: A lookup whose page matches a valid entry sets `lk_hit` in the same cycle and gives that entry's frame on `lk_pfn`. A miss gives `lk_hit`=0 and `lk_pfn`=0. `lk_hit` is never 1 without `lk_valid`.
- R3: A fill of a page not yet present goes to the slot named by a round-robin pointer. The pointer advances by one after each such fill and wraps after 8 entries. The ninth distinct fill evicts the first.
- R4: A fill of a page that is already valid overwrites that entry's frame and global flag in place. It does not advance the pointer, and at most one entry ever matches a page.
- R5: `base_wr` high for a cycle clears every entry whose global flag is 0 and keeps the global ones.
- R6: Every change of level on `flush_pin_n` (falling or rising) clears all entries. A level held steady clears nothing.
- R7: `range_wr` high for a cycle clears all entries.
- R8: A `ctl0_wr` whose old and new values differ in bit 31 (paging enable) or bit 0 (protection enable) clears all entries. A write differing only in other bits clears nothing.
- R9: A `ctl4_wr` whose old and new values differ in bit 4 (large pages), bit 5 (wide physical address) or bit 7 (global pages enable) clears all entries. Differences in other bits clear nothing.
- R10: A flush takes effect at the next clock edge, and a lookup in the flush cycle itself reports a miss.
- R11: A fill in the same cycle as a full flush is dropped. During a base-only flush the fill is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 20 | Frame of the hit entry, 0 on miss |
| fill_valid | input | 1 | Fill request |
| fill_vpn | input | 20 | Fill virtual page |
| fill_pfn | input | 20 | Fill frame |
| fill_global | input | 1 | Global flag of the filled entry |
| base_wr | input | 1 | Page-table base change, spares global entries |
| range_wr | input | 1 | Memory-type range register write |
| flush_pin_n | input | 1 | External active-low flush pin, both edges flush |
| ctl0_wr | input | 1 | Control register 0 write strobe |
| ctl0_old | input | 32 | Control register 0 value before write |
| ctl0_new | input | 32 | Control register 0 value written |
| ctl4_wr | input | 1 | Control register 4 write strobe |
| ctl4_old | input | 32 | Control register 4 value before write |
| ctl4_new | input | 32 | Control register 4 value written |

## Verification
The main function is run with a mix of global and non-global entries in place. A base-only flush must then split the population, while every forced trigger must empty it. Each control-register trigger is tried once with a toggle of a watched bit and once with a toggle of an unwatched bit, which tells a real bit-change decode apart from a plain write-strobe flush. The flush pin is toggled both ways and also held steady over several cycles, which tells edge detection apart from level sensing. Table-driven fills past capacity and a refill of a present page tell round-robin eviction apart from in-place update.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES      = 8,
  parameter int VPN_W        = 20,
  parameter int PFN_W        = 20,
  parameter int CTL_W        = 32,
  parameter int PAGING_BIT   = 31,
  parameter int PROTECT_BIT  = 0,
  parameter int BIGPAGE_BIT  = 4,
  parameter int WIDEADDR_BIT = 5,
  parameter int GLOBALEN_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_global,
  input  logic             base_wr,
  input  logic             range_wr,
  input  logic             flush_pin_n,
  input  logic             ctl0_wr,
  input  logic [CTL_W-1:0] ctl0_old,
  input  logic [CTL_W-1:0] ctl0_new,
  input  logic             ctl4_wr,
  input  logic [CTL_W-1:0] ctl4_old,
  input  logic [CTL_W-1:0] ctl4_new
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [CTL_W-1:0] CTL0_MASK =
    (CTL_W'(1) << PAGING_BIT) | (CTL_W'(1) << PROTECT_BIT);
  localparam logic [CTL_W-1:0] CTL4_MASK =
    (CTL_W'(1) << BIGPAGE_BIT) | (CTL_W'(1) << WIDEADDR_BIT) | (CTL_W'(1) << GLOBALEN_BIT);

  logic [ENTRIES-1:0] vld, glb, lk_match, fill_match;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [PTR_W-1:0]   ptr, fill_slot;
  logic               pin_q;

  wire pin_edge   = pin_q != flush_pin_n;
  wire ctl0_flush = ctl0_wr && |((ctl0_old ^ ctl0_new) & CTL0_MASK);
  wire ctl4_flush = ctl4_wr && |((ctl4_old ^ ctl4_new) & CTL4_MASK);
  wire full_flush = pin_edge || range_wr || ctl0_flush || ctl4_flush;
  wire part_flush = base_wr && !full_flush;
  wire fill_go    = fill_valid && !full_flush;
  wire fill_found = |fill_match;

  assign lk_hit = lk_valid && |lk_match && !full_flush && !base_wr;

  always_comb begin
    lk_pfn    = '0;
    fill_slot = ptr;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit && lk_match[i]) lk_pfn = lk_pfn | pfn_q[i];
      if (fill_match[i]) fill_slot = PTR_W'(i);
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign lk_match[i]   = vld[i] && (vpn_q[i] == lk_vpn);
    assign fill_match[i] = vld[i] && (vpn_q[i] == fill_vpn);

    always_ff @(posedge clk) begin
      if (!rst_n || full_flush) begin
        vld[i] <= 1'b0;
      end else if (fill_go && fill_slot == PTR_W'(i)) begin
        vld[i]   <= 1'b1;
        glb[i]   <= fill_global;
        vpn_q[i] <= fill_vpn;
        pfn_q[i] <= fill_pfn;
      end else if (part_flush && !glb[i]) begin
        vld[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= '0;
      pin_q <= 1'b1;
    end else begin
      pin_q <= flush_pin_n;
      if (fill_go && !fill_found)
        ptr <= (ptr == PTR_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES      = 8,
  parameter int CTL_W        = 32,
  parameter int PAGING_BIT   = 31,
  parameter int GLOBALEN_BIT = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_hit,
  input logic [ENTRIES-1:0] lk_match,
  input logic               fill_valid,
  input logic               base_wr,
  input logic               range_wr,
  input logic               flush_pin_n,
  input logic               ctl0_wr,
  input logic [CTL_W-1:0]   ctl0_old,
  input logic [CTL_W-1:0]   ctl0_new,
  input logic               ctl4_wr,
  input logic [CTL_W-1:0]   ctl4_old,
  input logic [CTL_W-1:0]   ctl4_new
);
  assert_hit_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid);
  assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  assert_flush_cycle_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (base_wr || range_wr) |-> !lk_hit);
  assert_range_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    range_wr |=> !lk_hit);
  assert_fill_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (range_wr && fill_valid) |=> !lk_hit);
  assert_pin_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_pin_n != $past(flush_pin_n)) |=> !lk_hit);
  assert_paging_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl0_wr && ctl0_old[PAGING_BIT] != ctl0_new[PAGING_BIT]) |=> !lk_hit);
  assert_global_en_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl4_wr && ctl4_old[GLOBALEN_BIT] != ctl4_new[GLOBALEN_BIT]) |=> !lk_hit);
endmodule

bind xlat_cache xlat_cache_chk #(
  .ENTRIES(ENTRIES), .CTL_W(CTL_W), .PAGING_BIT(PAGING_BIT), .GLOBALEN_BIT(GLOBALEN_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_match(lk_match),
  .fill_valid(fill_valid), .base_wr(base_wr), .range_wr(range_wr),
  .flush_pin_n(flush_pin_n), .ctl0_wr(ctl0_wr), .ctl0_old(ctl0_old),
  .ctl0_new(ctl0_new), .ctl4_wr(ctl4_wr), .ctl4_old(ctl4_old), .ctl4_new(ctl4_new)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;
  logic clk = 0, rst_n = 0;
  logic lk_valid, fill_valid, fill_global, base_wr, range_wr, flush_pin_n = 1;
  logic ctl0_wr, ctl4_wr, lk_hit;
  logic [19:0] lk_vpn, fill_vpn, fill_pfn, lk_pfn;
  logic [31:0] ctl0_old, ctl0_new, ctl4_old, ctl4_new;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xlat_cache i_xlat_cache (.*);

  typedef struct packed {
    logic is_fill; logic glb; logic hit; logic [19:0] vpn; logic [19:0] pfn;
  } vec_t;

  localparam vec_t VEC [21] = '{
    '{1'b1,1'b0,1'b0,20'h10,20'hA0010}, '{1'b1,1'b1,1'b0,20'h11,20'hA0011},
    '{1'b1,1'b0,1'b0,20'h12,20'hA0012}, '{1'b1,1'b1,1'b0,20'h13,20'hA0013},
    '{1'b1,1'b0,1'b0,20'h14,20'hA0014}, '{1'b1,1'b0,1'b0,20'h15,20'hA0015},
    '{1'b1,1'b0,1'b0,20'h16,20'hA0016}, '{1'b1,1'b0,1'b0,20'h17,20'hA0017},
    '{1'b0,1'b0,1'b1,20'h10,20'hA0010}, '{1'b0,1'b0,1'b1,20'h17,20'hA0017},
    '{1'b0,1'b0,1'b0,20'h20,20'h00000},
    '{1'b1,1'b0,1'b0,20'h18,20'hA0018}, '{1'b0,1'b0,1'b0,20'h10,20'h00000},
    '{1'b0,1'b0,1'b1,20'h18,20'hA0018}, '{1'b0,1'b0,1'b1,20'h11,20'hA0011},
    '{1'b1,1'b1,1'b0,20'h11,20'hB0011}, '{1'b0,1'b0,1'b1,20'h11,20'hB0011},
    '{1'b1,1'b0,1'b0,20'h19,20'hA0019}, '{1'b0,1'b0,1'b0,20'h11,20'h00000},
    '{1'b0,1'b0,1'b1,20'h12,20'hA0012}, '{1'b0,1'b0,1'b1,20'h19,20'hA0019}
  };

  task automatic clr();
    lk_valid = 0; lk_vpn = '0; fill_valid = 0; fill_vpn = '0; fill_pfn = '0;
    fill_global = 0; base_wr = 0; range_wr = 0;
    ctl0_wr = 0; ctl0_old = '0; ctl0_new = '0; ctl4_wr = 0; ctl4_old = '0; ctl4_new = '0;
  endtask

  task automatic chk(string req, logic eh, logic [19:0] ep);
    checks++;
    if (lk_hit !== eh || lk_pfn !== ep) begin
      errors++;
      $display("FAIL %s: hit=%b pfn=%h expected hit=%b pfn=%h", req, lk_hit, lk_pfn, eh, ep);
    end
  endtask

  task automatic look(string req, logic [19:0] v, logic eh, logic [19:0] ep);
    @(negedge clk); clr(); lk_valid = 1; lk_vpn = v; #1 chk(req, eh, ep);
  endtask

  task automatic fill(logic [19:0] v, logic [19:0] p, logic g);
    @(negedge clk); clr(); fill_valid = 1; fill_vpn = v; fill_pfn = p; fill_global = g;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clr();
    repeat (3) @(posedge clk);
    look("R1 reset lookup", 20'h10, 0, 0);
    look("R1 reset lookup zero", 20'h0, 0, 0);
    @(negedge clk); rst_n = 1;
    look("R1 after reset", 20'h10, 0, 0);

    for (int i = 0; i < 21; i++) begin
      if (VEC[i].is_fill) fill(VEC[i].vpn, VEC[i].pfn, VEC[i].glb);
      else look($sformatf("R2 R3 R4 vector %0d", i), VEC[i].vpn, VEC[i].hit, VEC[i].pfn);
    end

    // base flush: global 0x13 survives, 0x12 dropped (R5), lookup in that cycle misses (R10)
    @(negedge clk); clr(); base_wr = 1; lk_valid = 1; lk_vpn = 20'h13; #1 chk("R10 base cycle", 0, 0);
    look("R5 global kept", 20'h13, 1, 20'hA0013);
    look("R5 nonglobal cleared", 20'h12, 0, 0);
    look("R5 nonglobal cleared 2", 20'h19, 0, 0);
    // fill during base flush is kept (R11)
    @(negedge clk); clr(); base_wr = 1; fill_valid = 1; fill_vpn = 20'h40; fill_pfn = 20'hC0040;
    look("R11 fill kept on base flush", 20'h40, 1, 20'hC0040);

    // pin falling edge
    @(negedge clk); clr(); flush_pin_n = 0; lk_valid = 1; lk_vpn = 20'h13; #1 chk("R10 pin cycle", 0, 0);
    look("R6 fall clears global", 20'h13, 0, 0);
    fill(20'h30, 20'hC0030, 1);
    repeat (3) @(negedge clk);
    look("R6 steady low no flush", 20'h30, 1, 20'hC0030);
    @(negedge clk); clr(); flush_pin_n = 1;
    look("R6 rise clears", 20'h30, 0, 0);

    fill(20'h31, 20'hC0031, 1);
    @(negedge clk); clr(); range_wr = 1; lk_valid = 1; lk_vpn = 20'h31; #1 chk("R10 range cycle", 0, 0);
    look("R7 range clears", 20'h31, 0, 0);

    @(negedge clk); clr(); range_wr = 1; fill_valid = 1; fill_vpn = 20'h32; fill_pfn = 20'hC0032;
    look("R11 fill dropped", 20'h32, 0, 0);

    fill(20'h33, 20'hC0033, 1);
    @(negedge clk); clr(); ctl0_wr = 1; ctl0_old = 32'h0000_0001; ctl0_new = 32'h0000_0003;
    look("R8 other bit no flush", 20'h33, 1, 20'hC0033);
    @(negedge clk); clr(); ctl0_wr = 1; ctl0_old = 32'h0000_0001; ctl0_new = 32'h8000_0001;
    look("R8 paging flip", 20'h33, 0, 0);
    fill(20'h33, 20'hC0033, 1);
    @(negedge clk); clr(); ctl0_wr = 1; ctl0_old = 32'h8000_0001; ctl0_new = 32'h8000_0000;
    look("R8 protect flip", 20'h33, 0, 0);

    fill(20'h34, 20'hC0034, 1);
    @(negedge clk); clr(); ctl4_wr = 1; ctl4_old = 32'h0; ctl4_new = 32'h0000_0048;
    look("R9 other bits no flush", 20'h34, 1, 20'hC0034);
    @(negedge clk); clr(); ctl4_wr = 1; ctl4_old = 32'h0; ctl4_new = 32'h0000_0080;
    look("R9 global enable flip", 20'h34, 0, 0);
    fill(20'h34, 20'hC0034, 1);
    @(negedge clk); clr(); ctl4_wr = 1; ctl4_old = 32'h10; ctl4_new = 32'h0;
    look("R9 large page flip", 20'h34, 0, 0);
    fill(20'h34, 20'hC0034, 1);
    @(negedge clk); clr(); ctl4_wr = 1; ctl4_old = 32'h0; ctl4_new = 32'h20;
    look("R9 wide address flip", 20'h34, 0, 0);

    fill(20'h35, 20'hC0035, 0);
    @(negedge clk); clr(); rst_n = 0;
    @(negedge clk); rst_n = 1;
    look("R1 reset clears", 20'h35, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule